// File: doc/BRIEF.md
# Gap-Delimited Packet Serial Receiver

This block receives an asynchronous serial byte stream: one start bit, eight data bits sent least significant bit first, and one stop bit. It groups the bytes into packets, and a packet ends when the line stays quiet for a programmable number of bit times. The data bytes are packed into 32-bit words and stored in a data FIFO that holds up to 1024 bytes. When a packet is complete, its byte count goes into a separate count FIFO. Software first reads a count and then reads exactly as many words as that packet occupies.

A registered status word reports the number of completed packets waiting and a busy flag. It also carries two sticky error flags: one for a false start bit and one for an overrun. An enable input gates reception. A clear input aborts any receive in progress, resets the read and write positions of both FIFOs, and clears the sticky flags. The stored memory contents are not erased.

Top module: `gap_packet_uart_rx`

## Requirements
- R1: The line is sampled at the middle of each bit, `CLKS_PER_BIT` clocks per bit, with 8 data bits received least significant bit first.
- R2: A packet ends once the line has stayed idle for `gap_bits` bit times, counted from the middle of the last stop bit. Any shorter idle time leaves the packet open, and the next byte joins the same packet.
- R3: In each data word, the first byte of a packet occupies bits 7:0 and the following bytes fill bits 15:8, 23:16 and 31:24. Every packet starts in a fresh word, and unused upper bytes of a packet's last word read as zero.
- R4: At packet completion, the packet's byte count is pushed to the count FIFO. A pulse on `cnt_pop` (or `data_pop`) presents the oldest entry on `cnt_bytes` (or `data_word`) in the next cycle.
- R5: `status[20:16]` holds the number of completed packets waiting, up to 16. This number rises only when a packet completes, never when a packet starts, and falls with each count pop.
- R6: `status[7]` is 1 while a byte is being received or while the idle time of an open packet is still being counted. It is 0 otherwise.
- R7: While `rx_enable` is 0, start bits are ignored, so nothing is stored and the status word stays zero.
- R8: `status[0]` is set and stays set when the line reads high again at the middle of a start bit. Such an event stores no byte.
- R9: A write to a full FIFO drops the item and sets `status[1]`, which stays set. With the count FIFO full, the count of a 17th completed packet is dropped.
- R10: A pulse on `rx_clear` empties both FIFOs, aborts an open packet, and clears `status[1:0]` two cycles later.
- R11: After reset, `status` is zero and both empty flags are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Enables start-bit detection |
| rx_clear | input | 1 | Abort receive, reset FIFOs, clear sticky flags |
| gap_bits | input | 8 | Interpacket idle time in bit times |
| rxd | input | 1 | Serial input, idle high |
| data_pop | input | 1 | Pop one data word |
| data_word | output | 32 | Popped data word |
| data_empty | output | 1 | Data FIFO empty |
| cnt_pop | input | 1 | Pop one packet byte count |
| cnt_bytes | output | 11 | Popped packet byte count |
| cnt_empty | output | 1 | Count FIFO empty |
| status | output | 32 | [20:16] packets waiting, [7] busy, [1] overrun, [0] false start |

## Verification
The two FIFOs drift apart if the packing position is wrong, if the gap timer is off, or if a packet start is counted as a completion. When that happens, the first popped count disagrees with the bytes sent, or the word that follows carries bytes in the wrong lanes. Both show up within one packet read. A gap counter that never fires keeps `status[7]` high and the packet count at zero. A false start, an overrun or a clear shows up in `status[1:0]` within two cycles.

// File: rtl/gaprx_pkg.sv
package gaprx_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  localparam int STAT_FS_BIT   = 0;
  localparam int STAT_OVR_BIT  = 1;
  localparam int STAT_BUSY_BIT = 7;
  localparam int STAT_FRM_LSB  = 16;
endpackage

// File: rtl/gaprx_fifo.sv
module gaprx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         wr,
  input  logic [WIDTH-1:0]             wdata,
  input  logic                         rd,
  output logic [WIDTH-1:0]             rdata,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             wr_ok, rd_ok;

  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));
  assign wr_ok = wr && !full;
  assign rd_ok = rd && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wdata;
    if (rd_ok) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/gaprx_bit_sampler.sv
module gaprx_bit_sampler
  import gaprx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       enable,
  input  logic       rxd_s,
  output logic       byte_vld,
  output logic [7:0] byte_out,
  output logic       false_start,
  output logic       active
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2;

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;

  assign active = (state != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state       <= RX_IDLE;
      cnt         <= '0;
      idx         <= '0;
      byte_out    <= '0;
      byte_vld    <= 1'b0;
      false_start <= 1'b0;
    end else begin
      byte_vld    <= 1'b0;
      false_start <= 1'b0;
      case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (enable && !rxd_s) state <= RX_START;
        end
        RX_START: begin
          if (cnt == CW'(HALF-1)) begin
            cnt <= '0;
            idx <= '0;
            if (rxd_s) begin
              false_start <= 1'b1;
              state       <= RX_IDLE;
            end else begin
              state <= RX_DATA;
            end
          end else cnt <= cnt + 1'b1;
        end
        RX_DATA: begin
          if (cnt == CW'(CLKS_PER_BIT-1)) begin
            cnt      <= '0;
            byte_out <= {rxd_s, byte_out[7:1]};
            idx      <= idx + 1'b1;
            if (idx == 3'd7) state <= RX_STOP;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == CW'(CLKS_PER_BIT-1)) begin
            cnt      <= '0;
            byte_vld <= 1'b1;
            state    <= RX_IDLE;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/gaprx_packer.sv
module gaprx_packer #(
  parameter int CLKS_PER_BIT = 8,
  parameter int GAP_W        = 8,
  parameter int CNT_W        = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic             line_active,
  input  logic [GAP_W-1:0] gap_bits,
  output logic             data_wr,
  output logic [31:0]      data_wdata,
  output logic             cnt_wr,
  output logic [CNT_W-1:0] cnt_wdata,
  output logic             pkt_open
);
  localparam int CW = $clog2(CLKS_PER_BIT);

  logic [1:0]       lane;
  logic [31:0]      word_q;
  logic [CNT_W-1:0] byte_cnt;
  logic [CW-1:0]    tick_cnt;
  logic [GAP_W-1:0] idle_bits;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      lane       <= '0;
      word_q     <= '0;
      byte_cnt   <= '0;
      tick_cnt   <= '0;
      idle_bits  <= '0;
      pkt_open   <= 1'b0;
      data_wr    <= 1'b0;
      data_wdata <= '0;
      cnt_wr     <= 1'b0;
      cnt_wdata  <= '0;
    end else begin
      data_wr <= 1'b0;
      cnt_wr  <= 1'b0;
      if (byte_vld) begin
        pkt_open  <= 1'b1;
        byte_cnt  <= byte_cnt + 1'b1;
        tick_cnt  <= '0;
        idle_bits <= '0;
        lane      <= lane + 1'b1;
        if (lane == 2'd3) begin
          data_wr    <= 1'b1;
          data_wdata <= {byte_in, word_q[23:0]};
          word_q     <= '0;
        end else begin
          word_q[{lane, 3'b000} +: 8] <= byte_in;
        end
      end else if (line_active) begin
        tick_cnt  <= '0;
        idle_bits <= '0;
      end else if (pkt_open) begin
        if (idle_bits >= gap_bits) begin
          pkt_open  <= 1'b0;
          cnt_wr    <= 1'b1;
          cnt_wdata <= byte_cnt;
          byte_cnt  <= '0;
          lane      <= '0;
          word_q    <= '0;
          idle_bits <= '0;
          tick_cnt  <= '0;
          if (lane != 2'd0) begin
            data_wr    <= 1'b1;
            data_wdata <= word_q;
          end
        end else if (tick_cnt == CW'(CLKS_PER_BIT-1)) begin
          tick_cnt  <= '0;
          idle_bits <= idle_bits + 1'b1;
        end else begin
          tick_cnt <= tick_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/gap_packet_uart_rx.sv
module gap_packet_uart_rx
  import gaprx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int BUF_BYTES    = 1024,
  parameter int CNT_DEPTH    = 16,
  parameter int GAP_W        = 8,
  localparam int CNT_W       = $clog2(BUF_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_enable,
  input  logic             rx_clear,
  input  logic [GAP_W-1:0] gap_bits,
  input  logic             rxd,
  input  logic             data_pop,
  output logic [31:0]      data_word,
  output logic             data_empty,
  input  logic             cnt_pop,
  output logic [CNT_W-1:0] cnt_bytes,
  output logic             cnt_empty,
  output logic [31:0]      status
);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int FRM_W = $clog2(CNT_DEPTH + 1);
  localparam int DLW   = $clog2(WORDS + 1);

  logic             rxd_m, rxd_s;
  logic             byte_vld, fs_pulse, line_active;
  logic [7:0]       byte_val;
  logic             data_wr, cnt_wr, pkt_open;
  logic [31:0]      data_wdata;
  logic [CNT_W-1:0] cnt_wdata;
  logic             data_full, cnt_full;
  logic [FRM_W-1:0] frames;
  logic [DLW-1:0]   data_level;
  logic             ovr_q, fs_q;
  logic [31:0]      status_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  gaprx_bit_sampler #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_sampler (
    .clk(clk), .rst(rst), .abort(rx_clear), .enable(rx_enable), .rxd_s(rxd_s),
    .byte_vld(byte_vld), .byte_out(byte_val), .false_start(fs_pulse), .active(line_active)
  );

  gaprx_packer #(.CLKS_PER_BIT(CLKS_PER_BIT), .GAP_W(GAP_W), .CNT_W(CNT_W)) u_packer (
    .clk(clk), .rst(rst), .abort(rx_clear), .byte_vld(byte_vld), .byte_in(byte_val),
    .line_active(line_active), .gap_bits(gap_bits), .data_wr(data_wr),
    .data_wdata(data_wdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .pkt_open(pkt_open)
  );

  gaprx_fifo #(.WIDTH(32), .DEPTH(WORDS)) u_data_fifo (
    .clk(clk), .rst(rst), .clr(rx_clear), .wr(data_wr), .wdata(data_wdata),
    .rd(data_pop), .rdata(data_word), .empty(data_empty), .full(data_full), .level(data_level)
  );

  gaprx_fifo #(.WIDTH(CNT_W), .DEPTH(CNT_DEPTH)) u_cnt_fifo (
    .clk(clk), .rst(rst), .clr(rx_clear), .wr(cnt_wr), .wdata(cnt_wdata),
    .rd(cnt_pop), .rdata(cnt_bytes), .empty(cnt_empty), .full(cnt_full), .level(frames)
  );

  always_ff @(posedge clk) begin
    if (rst || rx_clear) begin
      ovr_q <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      if ((data_wr && data_full) || (cnt_wr && cnt_full)) ovr_q <= 1'b1;
      if (fs_pulse) fs_q <= 1'b1;
    end
  end

  always_comb begin
    status_d = '0;
    status_d[STAT_FRM_LSB +: FRM_W] = frames;
    status_d[STAT_BUSY_BIT]         = line_active || pkt_open;
    status_d[STAT_OVR_BIT]          = ovr_q;
    status_d[STAT_FS_BIT]           = fs_q;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= status_d;
  end
endmodule

// File: rtl/gaprx_checker.sv
module gaprx_checker #(
  parameter int CNT_DEPTH = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        rx_enable,
  input logic        rx_clear,
  input logic        data_empty,
  input logic        cnt_empty,
  input logic [31:0] status
);
  AST_FRAMES_BOUND: assert property (@(posedge clk) disable iff (rst)
    status[20:16] <= 5'(CNT_DEPTH)); // R5

  AST_FRAMES_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rx_clear) && !$past(rx_clear, 2)) |->
      ((status[20:16] == $past(status[20:16])) ||
       (status[20:16] == $past(status[20:16]) + 5'd1) ||
       (status[20:16] + 5'd1 == $past(status[20:16])))); // R5

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    rx_clear |=> (data_empty && cnt_empty)); // R10

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    rx_clear |=> ##1 (status[1:0] == 2'b00)); // R10

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rx_enable && !$past(rx_enable) && !status[7]) |=> !status[7]); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status[1] && !$past(rx_clear)) |=> status[1]); // R9

  AST_FS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status[0] && !$past(rx_clear)) |=> status[0]); // R8
endmodule

bind gap_packet_uart_rx gaprx_checker #(.CNT_DEPTH(CNT_DEPTH)) u_gaprx_checker (
  .clk(clk), .rst(rst), .rx_enable(rx_enable), .rx_clear(rx_clear),
  .data_empty(data_empty), .cnt_empty(cnt_empty), .status(status)
);

// File: tb/tb_gap_packet_uart_rx.sv
module tb_gap_packet_uart_rx;
  localparam int CPB = 8;
  localparam int GAP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_enable = 1'b1;
  logic        rx_clear = 1'b0;
  logic [7:0]  gap_bits = 8'(GAP);
  logic        rxd = 1'b1;
  logic        data_pop = 1'b0;
  logic [31:0] data_word;
  logic        data_empty;
  logic        cnt_pop = 1'b0;
  logic [10:0] cnt_bytes;
  logic        cnt_empty;
  logic [31:0] status;

  int nchk = 0;
  int nfail = 0;
  bit mon_en = 1'b0;
  logic [7:0]  tx_q[$];
  int          exp_cnt[$];
  logic [31:0] exp_words[$];

  always #2 clk = ~clk;

  gap_packet_uart_rx #(.CLKS_PER_BIT(CPB)) dut (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .rx_clear(rx_clear), .gap_bits(gap_bits),
    .rxd(rxd), .data_pop(data_pop), .data_word(data_word), .data_empty(data_empty),
    .cnt_pop(cnt_pop), .cnt_bytes(cnt_bytes), .cnt_empty(cnt_empty), .status(status)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  task automatic send_byte(input logic [7:0] b);
    rxd = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (CPB) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send_raw();
    foreach (tx_q[i]) send_byte(tx_q[i]);
  endtask

  task automatic wait_gap();
    repeat ((GAP + 3) * CPB) @(negedge clk);
  endtask

  // driver side of the scoreboard: expected count and packed words (R3, R4)
  task automatic expect_txq();
    logic [31:0] w;
    w = '0;
    foreach (tx_q[i]) begin
      w[(i % 4) * 8 +: 8] = tx_q[i];
      if ((i % 4 == 3) || (i == tx_q.size() - 1)) begin
        exp_words.push_back(w);
        w = '0;
      end
    end
    exp_cnt.push_back(tx_q.size());
  endtask

  task automatic send_pkt();
    expect_txq();
    send_raw();
    wait_gap();
  endtask

  task automatic drain(input string req);
    repeat (200) @(negedge clk);
    chk(exp_cnt.size() == 0 && exp_words.size() == 0, req,
        32'(exp_cnt.size()), 32'd0);
  endtask

  task automatic pulse_clear();
    rx_clear = 1'b1;
    @(negedge clk);
    rx_clear = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && !rst && !cnt_empty) begin
        int e;
        int nw;
        cnt_pop = 1'b1;
        @(negedge clk);
        cnt_pop = 1'b0;
        if (exp_cnt.size() == 0) begin
          chk(1'b0, "R4 unexpected packet", 32'(cnt_bytes), 32'd0);
          e = int'(cnt_bytes);
        end else begin
          e = exp_cnt.pop_front();
          chk(cnt_bytes == 11'(e), "R4 packet byte count", 32'(cnt_bytes), 32'(e));
        end
        nw = (e + 3) / 4;
        for (int i = 0; i < nw; i++) begin
          logic [31:0] ew;
          data_pop = 1'b1;
          @(negedge clk);
          data_pop = 1'b0;
          ew = (exp_words.size() != 0) ? exp_words.pop_front() : 32'hDEAD_BEEF;
          chk(data_word == ew, "R3 packed word", data_word, ew);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(status == 32'd0, "R11 status after reset", status, 32'd0);
    chk(data_empty && cnt_empty, "R11 empty flags after reset",
        {30'd0, data_empty, cnt_empty}, 32'd3);

    mon_en = 1'b1;
    // R1 R3 R4: single byte
    tx_q = '{8'hA5};
    send_pkt();
    // four bytes, exactly one word
    tx_q = '{8'h01, 8'h80, 8'hFF, 8'h00};
    send_pkt();
    // seven bytes, second word partial with zero upper byte
    tx_q = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
    send_pkt();
    drain("R3 packets drained");

    // R2: idle shorter than the gap keeps one packet
    tx_q = '{8'h5A, 8'hC3, 8'h3C};
    expect_txq();
    send_raw();
    repeat (2 * CPB) @(negedge clk);
    tx_q = '{8'h96, 8'h69};
    expect_txq();
    void'(exp_cnt.pop_back());
    void'(exp_cnt.pop_back());
    exp_cnt.push_back(5);
    void'(exp_words.pop_back());
    void'(exp_words.pop_back());
    exp_words.push_back(32'h963C_C35A);
    exp_words.push_back(32'h0000_0069);
    send_raw();
    wait_gap();
    drain("R2 short idle joins packet");

    // R5 R6: count rises only at completion, busy through the gap
    mon_en = 1'b0;
    tx_q = '{8'hE7, 8'h18};
    send_raw();
    chk(status[20:16] == 5'd0, "R5 no count before gap", 32'(status[20:16]), 32'd0);
    chk(status[7] == 1'b1, "R6 busy during gap", 32'(status[7]), 32'd1);
    repeat ((GAP + 2) * CPB) @(negedge clk);
    chk(status[20:16] == 5'd1, "R5 count after gap", 32'(status[20:16]), 32'd1);
    chk(status[7] == 1'b0, "R6 idle after gap", 32'(status[7]), 32'd0);
    expect_txq();
    mon_en = 1'b1;
    drain("R5 completed packet read");
    chk(status[20:16] == 5'd0, "R5 count after pop", 32'(status[20:16]), 32'd0);

    // R7: disabled receiver ignores traffic
    rx_enable = 1'b0;
    tx_q = '{8'h00, 8'h42};
    send_raw();
    wait_gap();
    chk(cnt_empty && data_empty, "R7 nothing stored while disabled",
        {30'd0, data_empty, cnt_empty}, 32'd3);
    chk(status == 32'd0, "R7 status quiet while disabled", status, 32'd0);
    rx_enable = 1'b1;

    // R8: short low glitch is a false start
    rxd = 1'b0;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * CPB) @(negedge clk);
    chk(status[0] == 1'b1, "R8 false start flagged", 32'(status[0]), 32'd1);
    chk(cnt_empty && data_empty, "R8 false start stores nothing",
        {30'd0, data_empty, cnt_empty}, 32'd3);
    repeat (4 * CPB) @(negedge clk);
    chk(status[0] == 1'b1, "R8 false start sticky", 32'(status[0]), 32'd1);
    pulse_clear();
    chk(status[0] == 1'b0, "R10 clear drops false start", 32'(status[0]), 32'd0);

    // R10: clear aborts an open packet
    tx_q = '{8'hAA, 8'hBB, 8'hCC};
    send_raw();
    pulse_clear();
    wait_gap();
    chk(cnt_empty && data_empty && status == 32'd0, "R10 aborted packet gone",
        status, 32'd0);

    // R10: clear discards stored packets
    mon_en = 1'b0;
    tx_q = '{8'h12, 8'h34};
    send_raw();
    wait_gap();
    chk(status[20:16] == 5'd1, "R5 stored before clear", 32'(status[20:16]), 32'd1);
    pulse_clear();
    chk(cnt_empty && data_empty && status == 32'd0, "R10 stored packet cleared",
        status, 32'd0);

    // R9: seventeenth packet overflows the count FIFO
    for (int k = 0; k < 17; k++) begin
      tx_q = '{8'(k + 1)};
      send_raw();
      wait_gap();
    end
    chk(status[20:16] == 5'd16, "R9 count FIFO holds 16", 32'(status[20:16]), 32'd16);
    chk(status[1] == 1'b1, "R9 overrun flagged", 32'(status[1]), 32'd1);
    pulse_clear();
    chk(status == 32'd0 && cnt_empty && data_empty, "R10 clear after overrun",
        status, 32'd0);

    // R1: receiver still works after clear
    mon_en = 1'b1;
    tx_q = '{8'h0F, 8'hF0, 8'h81};
    send_pkt();
    drain("R1 receive after clear");

    finish_run();
  end
endmodule